// File: doc/BRIEF.md
# Watchdog Mode Supervisor with Guarded Debug Entry

This block supervises the operating mode of a supply chip and runs its software watchdog. A host writes single bytes that an SPI front end has already received. Each byte holds a 3-bit register address in bits 7:5, a write-enable in bit 4 and four data bits in bits 3:0. After power-on the supervisor waits in a normal-request mode and keeps pulsing its active-low reset output until the host writes the timing register. That write also serves as the watchdog clear. It moves the block into normal mode and restarts the timeout counter. If the clears stop, the block drives reset low for a fixed number of clocks and falls back to normal-request mode.

A power-fail flag is set at power-on and is cleared when the host reads the mode register. While the flag is still set and the block is in normal mode, writing data 0000 to the mode register arms a debug entry. The next valid mode write then selects one of three debug modes (normal, standby or stop) in which the watchdog is switched off. Another 0000 write leaves debug and starts the watchdog again. A host that reads the flag first can no longer enter debug, because the arm step needs the flag.

Mode codes on `mode_o`:

| Code | Mode |
|------|------|
| 000 | normal-request |
| 001 | normal |
| 010 | standby |
| 011 | stop |
| 101 | normal debug |
| 110 | standby debug |
| 111 | stop debug |

Bit 2 of the code marks the debug modes.

Top module: `wdt_mode_ctrl`

## Requirements
- R1: After `por_n` is released, `mode_o` is 000, `rst_n_o` is 1 and `wdog_n_o` is 0, and the power-fail flag is set.
- R2: A timing-register write (address 001, bit 4 set, for example byte 0x30) made in normal-request mode moves the mode to normal (001). Made in any mode other than debug, it restarts the timeout count from zero.
- R3: In a mode other than debug, the count expires when no timing-register write arrives for PERIOD clock edges. On expiry `rst_n_o` goes low for exactly RST_LEN cycles and the mode becomes 000. With no writes at all, a new expiry follows PERIOD cycles after each pulse ends.
- R4: A timing-register write that arrives on the edge where the count would expire prevents the expiry and restarts the count.
- R5: `wdog_n_o` is low from power-on and after every expiry, and goes high on the first timing-register write after that.
- R6: A read strobe with `rd_addr` 000 loads `rd_data` on the next edge with {4'b0000, flag, mode code}. The read clears the flag. A read of any other address returns 0x00.
- R7: In normal mode with the flag set, a mode-register write (address 000) of data 0000 arms debug entry without changing the mode. The next mode write with data bits 2:0 equal to 101, 110 or 111 selects mode 101, 110 or 111. Data bit 3 is ignored. The flag clears on entry.
- R8: While in any debug mode, `rst_n_o` never goes low, however long no timing-register write arrives.
- R9: In a debug mode, a mode write of data 0000 returns the block to normal (001) with the count restarted, so expiry follows PERIOD edges later. A write of 101, 110 or 111 moves it to another debug mode.
- R10: Once the flag is clear, a data 0000 mode write has no effect, and no later write can enter a debug mode.
- R11: Outside debug and with debug not armed, a mode write with data bits 2:0 of 101, 110 or 111 selects normal, standby or stop (001, 010, 011). Other data codes are ignored. In normal-request mode, all mode writes are ignored.
- R12: These bytes are ignored: bytes with bit 4 clear, bytes with an address other than 000 or 001, and any byte written while `rst_n_o` is low.
- R13: A second data 0000 mode write while debug is armed cancels the arm and clears the flag. A following 101 write then selects plain normal mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low asynchronous power-on reset |
| wr_en | input | 1 | Write strobe for `wr_byte` |
| wr_byte | input | 8 | Received byte: address[7:5], write-enable[4], data[3:0] |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 3 | Register address to read |
| rd_data | output | 8 | Read result, valid from the edge after `rd_en` |
| rst_n_o | output | 1 | Active-low reset output |
| wdog_n_o | output | 1 | Active-low watchdog status |
| mode_o | output | 3 | Current mode code |

## Verification
A watchdog clear and a timeout can fall on the same clock edge, and the clear must win there. The bench sweeps the gap between two clears over every value from 1 to PERIOD+2 edges. The expected result is computed from the gap alone: a reset pulse and a fall back to normal-request mode for gaps larger than PERIOD, and no pulse otherwise. A gap of exactly PERIOD makes the two events coincide. The bench also writes a byte while a reset pulse is in progress and checks that the byte is dropped.

// File: rtl/wmc_pkg.sv
package wmc_pkg;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 4;
  localparam int BYTE_W = ADDR_W + 1 + DATA_W;

  localparam logic [ADDR_W-1:0] A_MODE = 3'b000;
  localparam logic [ADDR_W-1:0] A_TIM  = 3'b001;

  typedef enum logic [2:0] {
    M_NREQ  = 3'b000,
    M_NORM  = 3'b001,
    M_STBY  = 3'b010,
    M_STOP  = 3'b011,
    M_DNORM = 3'b101,
    M_DSTBY = 3'b110,
    M_DSTOP = 3'b111
  } mode_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              we;
    logic [DATA_W-1:0] data;
  } wbyte_t;

  function automatic logic is_dbg(input mode_e m);
    return m[2];
  endfunction

  // data bits 2:0 must be 101, 110 or 111 to pick a mode
  function automatic logic sel_ok(input logic [DATA_W-1:0] d);
    return d[2] && (d[1:0] != 2'b00);
  endfunction

  function automatic logic is_zero(input logic [DATA_W-1:0] d);
    return d == '0;
  endfunction

  function automatic mode_e plain_mode(input logic [DATA_W-1:0] d);
    return mode_e'({1'b0, d[1:0]});
  endfunction

  function automatic mode_e dbg_mode(input logic [DATA_W-1:0] d);
    return mode_e'({1'b1, d[1:0]});
  endfunction

  function automatic logic [BYTE_W-1:0] mode_word(input logic flag, input mode_e m);
    return {4'b0000, flag, m};
  endfunction

endpackage

// File: rtl/wmc_decode.sv
module wmc_decode
  import wmc_pkg::*;
(
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              hold,
  output logic              mode_wr,
  output logic              tim_wr,
  output logic [DATA_W-1:0] wdata
);

  wbyte_t b;
  logic   take;

  assign b       = wbyte_t'(wr_byte);
  assign take    = wr_en && b.we && !hold;
  assign mode_wr = take && (b.addr == A_MODE);
  assign tim_wr  = take && (b.addr == A_TIM);
  assign wdata   = b.data;

endmodule

// File: rtl/wmc_timer.sv
module wmc_timer #(
  parameter int PERIOD  = 2800000,
  parameter int RST_LEN = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic run,
  input  logic kick,
  output logic expire,
  output logic pulsing
);

  localparam int CW = $clog2(PERIOD + 1);
  localparam int PW = $clog2(RST_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  localparam logic [PW-1:0] PLEN = PW'(RST_LEN);

  logic [CW-1:0] cnt;
  logic [PW-1:0] pcnt;

  assign pulsing = (pcnt != '0);
  assign expire  = run && !pulsing && !kick && (cnt == LAST);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt  <= '0;
      pcnt <= '0;
    end else begin
      if (pulsing) pcnt <= pcnt - PW'(1);
      if (expire) begin
        pcnt <= PLEN;
        cnt  <= '0;
      end else if (!run || pulsing || kick) begin
        cnt <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

endmodule

// File: rtl/wmc_fsm.sv
module wmc_fsm
  import wmc_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              mode_wr,
  input  logic              tim_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output mode_e             mode,
  output logic              flag,
  output logic              armed,
  output logic              wd_ok,
  output logic [BYTE_W-1:0] rd_data
);

  logic rd_mode;
  assign rd_mode = rd_en && (rd_addr == A_MODE);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mode    <= M_NREQ;
      flag    <= 1'b1;
      armed   <= 1'b0;
      wd_ok   <= 1'b0;
      rd_data <= '0;
    end else begin
      if (rd_en) rd_data <= rd_mode ? mode_word(flag, mode) : '0;
      if (rd_mode) flag <= 1'b0;

      if (expire) begin
        mode  <= M_NREQ;
        armed <= 1'b0;
        wd_ok <= 1'b0;
      end else if (tim_wr) begin
        wd_ok <= 1'b1;
        if (mode == M_NREQ) mode <= M_NORM;
      end else if (mode_wr) begin
        if (mode == M_NREQ) begin
          mode <= M_NREQ;
        end else if (is_dbg(mode)) begin
          if (is_zero(wdata))      mode <= M_NORM;
          else if (sel_ok(wdata))  mode <= dbg_mode(wdata);
        end else if (armed) begin
          if (is_zero(wdata)) begin
            armed <= 1'b0;
            flag  <= 1'b0;
          end else if (sel_ok(wdata)) begin
            mode  <= dbg_mode(wdata);
            armed <= 1'b0;
            flag  <= 1'b0;
          end
        end else begin
          if (is_zero(wdata) && flag && (mode == M_NORM)) armed <= 1'b1;
          else if (sel_ok(wdata))                          mode  <= plain_mode(wdata);
        end
      end
    end
  end

endmodule

// File: rtl/wdt_mode_ctrl.sv
module wdt_mode_ctrl
  import wmc_pkg::*;
#(
  parameter int PERIOD  = 2800000,
  parameter int RST_LEN = 16
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       wr_en,
  input  logic [7:0] wr_byte,
  input  logic       rd_en,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       rst_n_o,
  output logic       wdog_n_o,
  output logic [2:0] mode_o
);

  logic              mode_wr_w;
  logic              tim_wr_w;
  logic [DATA_W-1:0] wdata_w;
  logic              expire_w;
  logic              pulsing_w;
  logic              flag_w;
  logic              armed_w;
  logic              wd_ok_w;
  logic              run_w;
  mode_e             mode_w;

  wmc_decode u_dec (
    .wr_en   (wr_en),
    .wr_byte (wr_byte),
    .hold    (pulsing_w),
    .mode_wr (mode_wr_w),
    .tim_wr  (tim_wr_w),
    .wdata   (wdata_w)
  );

  assign run_w = !is_dbg(mode_w);

  wmc_timer #(.PERIOD(PERIOD), .RST_LEN(RST_LEN)) u_tmr (
    .clk     (clk),
    .por_n   (por_n),
    .run     (run_w),
    .kick    (tim_wr_w),
    .expire  (expire_w),
    .pulsing (pulsing_w)
  );

  wmc_fsm u_fsm (
    .clk     (clk),
    .por_n   (por_n),
    .mode_wr (mode_wr_w),
    .tim_wr  (tim_wr_w),
    .wdata   (wdata_w),
    .expire  (expire_w),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .mode    (mode_w),
    .flag    (flag_w),
    .armed   (armed_w),
    .wd_ok   (wd_ok_w),
    .rd_data (rd_data)
  );

  assign rst_n_o  = !pulsing_w;
  assign wdog_n_o = wd_ok_w;
  assign mode_o   = mode_w;

endmodule

// File: rtl/wmc_chk.sv
module wmc_chk (
  input logic       clk,
  input logic       por_n,
  input logic [2:0] mode_o,
  input logic       rst_n_o,
  input logic       wdog_n_o,
  input logic       expire,
  input logic       kick,
  input logic       flag,
  input logic       armed,
  input logic       rd_en,
  input logic [2:0] rd_addr
);

  p_expire_nreq_r3: assert property (@(posedge clk) disable iff (!por_n)
    expire |=> (mode_o == 3'b000) && !rst_n_o);

  p_pulse_hold_r12: assert property (@(posedge clk) disable iff (!por_n)
    !rst_n_o |=> (mode_o == 3'b000));

  p_kick_wins_r4: assert property (@(posedge clk) disable iff (!por_n)
    kick |=> rst_n_o);

  p_wdog_low_r5: assert property (@(posedge clk) disable iff (!por_n)
    expire |=> !wdog_n_o);

  p_read_clears_r6: assert property (@(posedge clk) disable iff (!por_n)
    (rd_en && rd_addr == 3'b000) |=> !flag);

  p_dbg_entry_r7: assert property (@(posedge clk) disable iff (!por_n)
    $rose(mode_o[2]) |-> $past(armed));

  p_dbg_no_reset_r8: assert property (@(posedge clk) disable iff (!por_n)
    mode_o[2] |-> rst_n_o);

  p_flag_stays_r10: assert property (@(posedge clk) disable iff (!por_n)
    !flag |=> !flag);

endmodule

bind wdt_mode_ctrl wmc_chk u_chk (
  .clk      (clk),
  .por_n    (por_n),
  .mode_o   (mode_o),
  .rst_n_o  (rst_n_o),
  .wdog_n_o (wdog_n_o),
  .expire   (expire_w),
  .kick     (tim_wr_w),
  .flag     (flag_w),
  .armed    (armed_w),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr)
);

// File: tb/sim_wdt_mode_ctrl.sv
`timescale 1ns/1ps
module sim_wdt_mode_ctrl;

  localparam int P = 20;
  localparam int RL = 4;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic       rd_en = 1'b0;
  logic [2:0] rd_addr = 3'b000;
  logic [7:0] rd_data;
  logic       rst_n_o, wdog_n_o;
  logic [2:0] mode_o;

  int n_chk = 0;
  int n_bad = 0;
  int low_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdt_mode_ctrl #(.PERIOD(P), .RST_LEN(RL)) u0 (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_byte(wr_byte),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rst_n_o(rst_n_o), .wdog_n_o(wdog_n_o), .mode_o(mode_o)
  );

  always @(negedge clk) if (por_n && !rst_n_o) low_cnt <= low_cnt + 1;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] b);
    wr_en = 1'b1; wr_byte = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic power_on();
    por_n = 1'b0;
    idle(2);
    por_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int n, l, g, base;
    @(negedge clk);

    // R1 reset state
    power_on();
    chk("R1 mode", mode_o, 0);
    chk("R1 rst", rst_n_o, 1);
    chk("R1 wdog", wdog_n_o, 0);
    rd(3'b000, v);
    chk("R1/R6 flag read", v, 8'h08);
    rd(3'b011, v);
    chk("R6 other addr", v, 8'h00);

    // R3 repeating pulses in normal-request mode
    power_on();
    n = 0;
    do begin @(negedge clk); n++; end while (rst_n_o);
    chk("R3 first expiry", n, P);
    chk("R3 mode in pulse", mode_o, 0);
    chk("R5 wdog low", wdog_n_o, 0);
    l = 0;
    while (!rst_n_o) begin l++; @(negedge clk); end
    chk("R3 pulse length", l, RL);
    g = 0;
    while (rst_n_o) begin g++; @(negedge clk); end
    chk("R3 gap", g, P);
    wr(8'h30);  // lands inside the pulse
    idle(RL + 1);
    chk("R12 write during pulse", mode_o, 0);
    chk("R12 wdog after pulse write", wdog_n_o, 0);

    // R2/R4 sweep of the gap between two clears
    power_on();
    for (int d = 1; d <= P + 2; d++) begin
      idle(RL + 2);
      wr(8'h30);
      chk("R2 to normal", mode_o, 1);
      chk("R5 wdog high", wdog_n_o, 1);
      base = low_cnt;
      idle(d - 1);
      wr(8'h30);
      idle(1);
      chk("R4 expiry vs gap", (low_cnt != base) ? 1 : 0, (d > P) ? 1 : 0);
      chk("R3 mode after gap", mode_o, (d > P) ? 0 : 1);
      chk("R5 wdog after gap", wdog_n_o, (d > P) ? 0 : 1);
    end

    // R7/R8/R9 debug entry, stay, exit
    power_on();
    wr(8'h30);
    wr(8'h10);
    chk("R7 arm keeps mode", mode_o, 1);
    wr(8'h1E);
    chk("R7 standby debug, bit3 ignored", mode_o, 3'b110);
    rd(3'b000, v);
    chk("R7 flag cleared on entry", v, 8'h06);
    base = low_cnt;
    idle(3 * P);
    chk("R8 no reset in debug", low_cnt - base, 0);
    wr(8'h17);
    chk("R9 switch to stop debug", mode_o, 3'b111);
    idle(2 * P);
    chk("R8 no reset in stop debug", low_cnt - base, 0);
    wr(8'h10);
    chk("R9 exit to normal", mode_o, 1);
    idle(P - 1);
    chk("R9 no expiry before PERIOD", rst_n_o, 1);
    idle(1);
    chk("R9 expiry at PERIOD", rst_n_o, 0);

    // normal debug variant
    power_on();
    wr(8'h30);
    wr(8'h10);
    wr(8'h15);
    chk("R7 normal debug", mode_o, 3'b101);

    // R10/R11/R12 flag cleared first, plain mode writes
    power_on();
    wr(8'h16);
    chk("R11 ignored in normal-request", mode_o, 0);
    wr(8'h30);
    rd(3'b000, v);
    chk("R6 read flag+mode", v, 8'h09);
    rd(3'b000, v);
    chk("R6 flag cleared", v, 8'h01);
    wr(8'h10);
    wr(8'h30);
    wr(8'h16);
    chk("R10 no debug after read", mode_o, 3'b010);
    wr(8'h17);
    chk("R11 stop", mode_o, 3'b011);
    wr(8'h15);
    chk("R11 normal", mode_o, 3'b001);
    wr(8'h13);
    chk("R11 invalid code ignored", mode_o, 3'b001);
    wr(8'h06);
    chk("R12 write-enable clear ignored", mode_o, 3'b001);
    wr(8'hB6);
    chk("R12 unused address ignored", mode_o, 3'b001);

    // R13 disarm
    power_on();
    wr(8'h30);
    wr(8'h10);
    wr(8'h10);
    wr(8'h15);
    chk("R13 disarm gives plain normal", mode_o, 3'b001);
    rd(3'b000, v);
    chk("R13 flag cleared", v, 8'h01);

    finish_run();
  end

endmodule